// File: doc/BRIEF.md
# SDRAM Open-Page Tracker and Burst Sequencer

This block sits between a request source and an SDRAM command engine. Each request carries a 32-bit byte address and two flags: write, and whole-line read. The block splits the address into chip select, bank, row and column. It keeps one open-row record per chip select, holding a valid flag, the bank and the row. From that record it classifies each access:

- **idle**: nothing is open for that chip select, so the engine activates the row and then reads or writes.
- **hit**: the same bank and row are already open, so the engine goes straight to the column command.
- **miss**: a different page is open, so the engine precharges, activates the new row, then reads or writes.

After classifying, the block writes the new bank and row into the record.

Whole-line reads become a four-beat burst of 32-bit words. The burst starts at the requested word, the critical word, and wraps within the 16-byte line. Every other access is a single beat. The beats leave on a valid/ready stream. New requests are refused while a burst is still being issued. A precharge-all pulse drops every open-row record, for use ahead of refresh or self-refresh.

Top module: `sdram_page_seq`

## Requirements
- R1: After reset, req_ready_o is 1, beat_valid_o is 0, and no chip select has an open row.
- R2: Address fields are taken as follows: column = addr[12:2], bank = addr[14:13], row = addr[27:15], chip select = addr[29:28]. The beat outputs carry the fields of the accepted request.
- R3: If the addressed chip select has no open row, the class is idle (beat_class_o = 2'd0).
- R4: If the open row of the addressed chip select has the same bank and row, the class is hit (2'd1).
- R5: If a different bank or row is open for the chip select, the class is miss (2'd2). After any access, the record holds the new bank and row.
- R6: Accesses to one chip select never change the record of another chip select.
- R7: A cycle with pre_all_i = 1 clears every record. A request accepted in that same cycle sees the cleared state, so it is classified idle, and it then opens its row.
- R8: A read with req_line_i = 1 gives 4 beats. Column bits [1:0] start at the requested value and step by +1 modulo 4, while the upper column bits stay fixed. beat_first_o is 1 on beat 0 only, and beat_last_o is 1 on beat 3 only.
- R9: A write, or a read with req_line_i = 0, gives one beat with both beat_first_o and beat_last_o set. beat_write_o reflects req_write_i.
- R10: The first beat is valid in the cycle after acceptance. req_ready_o stays 0 from acceptance until the last beat is taken. A beat held with beat_ready_i = 0 keeps all of its fields.
- R11: Address bits [31:30] and [1:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_addr_i | input | 32 | Byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_line_i | input | 1 | Whole-line read, critical word first |
| pre_all_i | input | 1 | Clear every open-row record |
| beat_valid_o | output | 1 | Beat present |
| beat_ready_i | input | 1 | Downstream takes the beat |
| beat_cs_o | output | 2 | Chip select of the access |
| beat_bank_o | output | 2 | Bank of the access |
| beat_row_o | output | 13 | Row of the access |
| beat_col_o | output | 11 | Word column of this beat |
| beat_write_o | output | 1 | Access is a write |
| beat_class_o | output | 2 | 0 idle, 1 hit, 2 miss |
| beat_first_o | output | 1 | First beat of the access |
| beat_last_o | output | 1 | Last beat of the access |

## Verification
The bench builds the block with its default parameters: four chip selects, 2-bit bank, 13-bit row, 11-bit column and four-beat lines. This lets it check the exact field positions and the modulo-4 wrap at every start offset. The random stimulus draws rows from only three values and banks from two, so hits, bank misses and row misses all occur often on every chip select. Precharge-all pulses sometimes land in the same cycle as an accept. Downstream back-pressure is random, so bursts are stretched and held mid-line.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_MISS = 2'd2
  } acc_class_e;

  // 32-bit data bus: two byte-offset bits below the column
  localparam int unsigned COL_LSB = 2;
endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CS_W   = 2,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CS_W-1:0]   cs_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  import sdram_seq_pkg::*;

  localparam int unsigned BANK_LSB = COL_LSB + COL_W;
  localparam int unsigned ROW_LSB  = BANK_LSB + BANK_W;
  localparam int unsigned CS_LSB   = ROW_LSB + ROW_W;

  assign col_o  = addr_i[COL_LSB +: COL_W];
  assign bank_o = addr_i[BANK_LSB +: BANK_W];
  assign row_o  = addr_i[ROW_LSB +: ROW_W];
  assign cs_o   = addr_i[CS_LSB +: CS_W];
endmodule

// File: rtl/sdram_open_rows.sv
module sdram_open_rows #(
  parameter int unsigned CS_N   = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 13,
  localparam int unsigned CS_W  = $clog2(CS_N)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_all_i,
  input  logic                       upd_i,
  input  logic [CS_W-1:0]            cs_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  output sdram_seq_pkg::acc_class_e  class_o
);
  import sdram_seq_pkg::*;

  logic              vld_a  [CS_N];
  logic [BANK_W-1:0] bank_a [CS_N];
  logic [ROW_W-1:0]  row_a  [CS_N];

  for (genvar g = 0; g < CS_N; g++) begin : g_rec
    logic              v_q;
    logic [BANK_W-1:0] b_q;
    logic [ROW_W-1:0]  r_q;
    logic              sel;

    assign sel = upd_i && (cs_i == CS_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        b_q <= '0;
        r_q <= '0;
      end else if (sel) begin
        v_q <= 1'b1;
        b_q <= bank_i;
        r_q <= row_i;
      end else if (clr_all_i) begin
        v_q <= 1'b0;
      end
    end

    assign vld_a[g]  = v_q;
    assign bank_a[g] = b_q;
    assign row_a[g]  = r_q;
  end

  // a clear in the lookup cycle wins over the stored state
  logic open_now, same_page;
  assign open_now  = vld_a[cs_i] && !clr_all_i;
  assign same_page = (bank_a[cs_i] == bank_i) && (row_a[cs_i] == row_i);

  always_comb begin
    if (!open_now)      class_o = ACC_IDLE;
    else if (same_page) class_o = ACC_HIT;
    else                class_o = ACC_MISS;
  end
endmodule

// File: rtl/sdram_burst_cols.sv
module sdram_burst_cols #(
  parameter int unsigned COL_W      = 11,
  parameter int unsigned LINE_BEATS = 4,
  localparam int unsigned IDX_W     = $clog2(LINE_BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             multi_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             adv_i,
  output logic             busy_o,
  output logic [COL_W-1:0] col_o,
  output logic             first_o,
  output logic             last_o
);
  logic                   busy_q, multi_q;
  logic [COL_W-1:IDX_W]   base_q;
  logic [IDX_W-1:0]       ofs_q, cnt_q;

  assign last_o  = !multi_q || (cnt_q == IDX_W'(LINE_BEATS - 1));
  assign first_o = (cnt_q == '0);
  assign col_o   = {base_q, ofs_q};
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      multi_q <= 1'b0;
      base_q  <= '0;
      ofs_q   <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      multi_q <= multi_i;
      base_q  <= col_i[COL_W-1:IDX_W];
      ofs_q   <= col_i[IDX_W-1:0];
      cnt_q   <= '0;
    end else if (adv_i) begin
      if (last_o) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        ofs_q <= ofs_q + 1'b1;  // wraps inside the line
      end
    end
  end
endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CS_N       = 4,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned ROW_W      = 13,
  parameter int unsigned COL_W      = 11,
  parameter int unsigned LINE_BEATS = 4,
  localparam int unsigned CS_W      = $clog2(CS_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_line_i,
  input  logic              pre_all_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [CS_W-1:0]   beat_cs_o,
  output logic [BANK_W-1:0] beat_bank_o,
  output logic [ROW_W-1:0]  beat_row_o,
  output logic [COL_W-1:0]  beat_col_o,
  output logic              beat_write_o,
  output logic [1:0]        beat_class_o,
  output logic              beat_first_o,
  output logic              beat_last_o
);
  import sdram_seq_pkg::*;

  logic [CS_W-1:0]   dec_cs;
  logic [BANK_W-1:0] dec_bank;
  logic [ROW_W-1:0]  dec_row;
  logic [COL_W-1:0]  dec_col;
  acc_class_e        look_cls;
  logic              busy, accept, adv;

  assign accept      = req_valid_i && !busy;
  assign adv         = busy && beat_ready_i;
  assign req_ready_o = !busy;

  sdram_addr_split #(
    .ADDR_W(ADDR_W), .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_split (
    .addr_i (req_addr_i),
    .cs_o   (dec_cs),
    .bank_o (dec_bank),
    .row_o  (dec_row),
    .col_o  (dec_col)
  );

  sdram_open_rows #(
    .CS_N(CS_N), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (pre_all_i),
    .upd_i     (accept),
    .cs_i      (dec_cs),
    .bank_i    (dec_bank),
    .row_i     (dec_row),
    .class_o   (look_cls)
  );

  sdram_burst_cols #(
    .COL_W(COL_W), .LINE_BEATS(LINE_BEATS)
  ) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .multi_i (req_line_i && !req_write_i),
    .col_i   (dec_col),
    .adv_i   (adv),
    .busy_o  (busy),
    .col_o   (beat_col_o),
    .first_o (beat_first_o),
    .last_o  (beat_last_o)
  );

  logic [CS_W-1:0]   cs_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic              wr_q;
  acc_class_e        cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '0;
      bank_q <= '0;
      row_q  <= '0;
      wr_q   <= 1'b0;
      cls_q  <= ACC_IDLE;
    end else if (accept) begin
      cs_q   <= dec_cs;
      bank_q <= dec_bank;
      row_q  <= dec_row;
      wr_q   <= req_write_i;
      cls_q  <= look_cls;
    end
  end

  assign beat_valid_o = busy;
  assign beat_cs_o    = cs_q;
  assign beat_bank_o  = bank_q;
  assign beat_row_o   = row_q;
  assign beat_write_o = wr_q;
  assign beat_class_o = cls_q;
endmodule

// File: rtl/sdram_page_seq_chk.sv
module sdram_page_seq_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CS_W       = 2,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned ROW_W      = 13,
  parameter int unsigned COL_W      = 11,
  parameter int unsigned LINE_BEATS = 4,
  localparam int unsigned IDX_W     = $clog2(LINE_BEATS),
  localparam int unsigned ROW_LSB   = 2 + COL_W + BANK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_write_i,
  input logic              req_line_i,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [BANK_W-1:0] beat_bank_o,
  input logic [ROW_W-1:0]  beat_row_o,
  input logic [COL_W-1:0]  beat_col_o,
  input logic [1:0]        beat_class_o,
  input logic              beat_first_o,
  input logic              beat_last_o
);
  // R10
  held_beat_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_col_o)
      && $stable(beat_row_o) && $stable(beat_bank_o) && $stable(beat_class_o)
      && $stable(beat_last_o));

  // R10
  no_accept_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !req_ready_o);

  // R10
  done_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && beat_last_o |=> !beat_valid_o && req_ready_o);

  // R8
  wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && !beat_last_o |=>
      beat_col_o[IDX_W-1:0] == IDX_W'($past(beat_col_o[IDX_W-1:0]) + 1'b1)
      && beat_col_o[COL_W-1:IDX_W] == $past(beat_col_o[COL_W-1:IDX_W])
      && !beat_first_o);

  // R8
  critical_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> beat_valid_o && beat_first_o
      && beat_col_o == $past(req_addr_i[2 +: COL_W])
      && beat_row_o == $past(req_addr_i[ROW_LSB +: ROW_W]));

  // R9
  single_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && (req_write_i || !req_line_i) |=> beat_first_o && beat_last_o);

  // R3 R4 R5
  class_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> beat_class_o != 2'd3);
endmodule

bind sdram_page_seq sdram_page_seq_chk #(
  .ADDR_W(ADDR_W), .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
  .COL_W(COL_W), .LINE_BEATS(LINE_BEATS)
) u_chk (.*);

// File: tb/tb_sdram_page_seq.sv
module tb_sdram_page_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_line_i = 1'b0;
  logic        pre_all_i = 1'b0;
  logic        beat_valid_o;
  logic        beat_ready_i = 1'b0;
  logic [1:0]  beat_cs_o;
  logic [1:0]  beat_bank_o;
  logic [12:0] beat_row_o;
  logic [10:0] beat_col_o;
  logic        beat_write_o;
  logic [1:0]  beat_class_o;
  logic        beat_first_o;
  logic        beat_last_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdram_page_seq dut (.*);

  typedef struct packed {
    logic [1:0]  cs;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [10:0] col;
    logic        wr;
    logic [1:0]  cls;
    logic        first;
    logic        last;
  } beat_t;

  beat_t       exp_q[$];
  bit          m_vld [4];
  logic [1:0]  m_bank[4];
  logic [12:0] m_row [4];
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  function automatic logic [31:0] mk(input logic [1:0] top, input logic [1:0] cs,
                                     input logic [1:0] bank, input int row, input int col);
    return {top, cs, 13'(row), bank, 11'(col), 2'b00};
  endfunction

  // reference model, updated on every rising edge
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      exp_q.delete();
      for (int i = 0; i < 4; i++) m_vld[i] = 0;
    end else begin
      bit acc;
      acc = req_valid_i && (exp_q.size() == 0);
      if (exp_q.size() != 0 && beat_ready_i) void'(exp_q.pop_front());
      if (pre_all_i) for (int i = 0; i < 4; i++) m_vld[i] = 0;
      if (acc) begin
        logic [1:0] cs, bk, cls;
        logic [12:0] rw;
        logic [10:0] cl;
        int n;
        cs = req_addr_i[29:28]; rw = req_addr_i[27:15];
        bk = req_addr_i[14:13]; cl = req_addr_i[12:2];
        if (!m_vld[cs]) cls = 2'd0;
        else if (m_bank[cs] == bk && m_row[cs] == rw) cls = 2'd1;
        else cls = 2'd2;
        m_vld[cs] = 1; m_bank[cs] = bk; m_row[cs] = rw;
        n = (req_line_i && !req_write_i) ? 4 : 1;
        for (int i = 0; i < n; i++) begin
          beat_t b;
          b.cs = cs; b.bank = bk; b.row = rw; b.wr = req_write_i; b.cls = cls;
          b.col = {cl[10:2], 2'(cl[1:0] + i)};
          b.first = (i == 0); b.last = (i == n - 1);
          exp_q.push_back(b);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      bit ev;
      ev = exp_q.size() != 0;
      chk(req_ready_o == !ev, "R1 R10 req_ready_o", 32'(req_ready_o), 32'(!ev));
      chk(beat_valid_o == ev, "R1 R10 beat_valid_o", 32'(beat_valid_o), 32'(ev));
      if (ev && beat_valid_o) begin
        beat_t e;
        e = exp_q[0];
        chk(beat_cs_o == e.cs, "R2 R11 cs", 32'(beat_cs_o), 32'(e.cs));
        chk(beat_bank_o == e.bank, "R2 R11 bank", 32'(beat_bank_o), 32'(e.bank));
        chk(beat_row_o == e.row, "R2 R11 row", 32'(beat_row_o), 32'(e.row));
        chk(beat_col_o == e.col, "R2 R8 col", 32'(beat_col_o), 32'(e.col));
        chk(beat_write_o == e.wr, "R9 write", 32'(beat_write_o), 32'(e.wr));
        chk(beat_class_o == e.cls, "R3 R4 R5 R6 R7 class", 32'(beat_class_o), 32'(e.cls));
        chk(beat_first_o == e.first, "R8 R9 first", 32'(beat_first_o), 32'(e.first));
        chk(beat_last_o == e.last, "R8 R9 last", 32'(beat_last_o), 32'(e.last));
      end
    end
  end

  always @(negedge clk_i) beat_ready_i = ($urandom_range(0, 3) != 0);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input logic [31:0] a, input bit wr, input bit line, input bit pa);
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = a; req_write_i = wr; req_line_i = line; pre_all_i = pa;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0; pre_all_i = 0;
  endtask

  task automatic pulse_pre();
    @(negedge clk_i);
    pre_all_i = 1;
    @(negedge clk_i);
    pre_all_i = 0;
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;  // R1: reset state checked by the comparator above
    send(mk(0, 0, 0, 5, 'h10), 0, 1, 0);   // R3 idle, R8 start at offset 0
    send(mk(0, 0, 0, 5, 'h12), 0, 1, 0);   // R4 hit, R8 wrap 2,3,0,1
    send(mk(0, 0, 0, 5, 'h1F), 0, 1, 0);   // R8 wrap from offset 3
    send(mk(0, 0, 1, 5, 'h03), 1, 1, 0);   // R5 bank miss, R9 write is one beat
    send(mk(0, 0, 1, 6, 'h03), 0, 0, 0);   // R5 row miss, R9 single read
    send(mk(0, 1, 1, 6, 'h07), 0, 1, 0);   // R6 other chip select idle
    send(mk(0, 0, 1, 6, 'h08), 0, 0, 0);   // R6 cs0 record kept -> hit
    send(mk(3, 0, 1, 6, 'h09), 0, 0, 0);   // R11 top bits ignored -> hit
    send(mk(0, 0, 1, 6, 'h09) | 32'h3, 0, 1, 0); // R11 byte offset ignored
    pulse_pre();                           // R7 clear all
    send(mk(0, 0, 1, 6, 'h09), 0, 0, 0);   // R7 idle after clear
    send(mk(0, 1, 1, 6, 'h01), 0, 1, 1);   // R7 clear in accept cycle -> idle
    send(mk(0, 1, 1, 6, 'h02), 0, 0, 0);   // R7 record reopened -> hit
    for (int k = 0; k < 400; k++) begin
      send(mk(2'($urandom), 2'($urandom), 2'($urandom_range(0, 1)),
              $urandom_range(0, 2), $urandom_range(0, 2047)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 15) == 0);
    end
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule